// File: doc/BRIEF.md
# Dead Band Non-Overlap Generator

This block turns a single phase input into a pair of complementary outputs that are never high at the same time. The phase input comes either from a PWM signal that is synchronous to the block clock, or from a bit that software toggles. That bit passes through a synchroniser before it is used. Each change of the phase input drops whichever output is high. A down counter then reloads from the period register and runs to zero. Only after that does the output that belongs to the new input level rise. The primary output follows the high level of the input and the auxiliary output follows the low level.

The period register sets the width of the gap. The current count can be read back on its own output. While the block is disabled, a period write also presets the count. An asynchronous kill input forces both outputs low at once, without waiting for a clock. After kill is released, the outputs stay low until a fresh input edge completes a full count.

Top module: `dead_band_gen`

## Requirements
- R1: While reset is asserted and after it is released, both outputs are low and the count readback is 0.
- R2: The primary and auxiliary outputs are never high at the same time.
- R3: An input edge that is detected while the block is enabled drives both outputs low from the next clock.
- R4: With period value P, the count readback shows P in the first cycle after the detecting edge and falls by one per clock to 0. The new output rises one clock after the count reaches 0, so both outputs are low for P+1 cycles. With P=0 the gap is one cycle.
- R5: After a rising input edge the primary output goes high. After a falling input edge the auxiliary output goes high. The other output stays low.
- R6: An input edge that arrives before the count reaches 0 reloads the count from the period. Neither output rises until that new count finishes.
- R7: A period write while disabled loads the count readback with the written value on the next clock. A period write while enabled leaves the count readback unchanged and takes effect at the next input edge.
- R8: While disabled, both outputs are low from the next clock. Input edges then do not change the count readback.
- R9: While kill is high, both outputs are low, and this takes effect without a clock edge.
- R10: After kill is released, both outputs stay low until a later input edge completes a full count.
- R11: Source select 0 uses the PWM input, and a change set up before clock edge k is detected at edge k. Source select 1 uses the software bit through a two-stage synchroniser, so the change is detected at edge k+2. The input that is not selected has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| src_sel | input | 1 | Phase source: 0 PWM input, 1 software bit |
| pwm_in | input | 1 | PWM phase input, synchronous to clk |
| sw_bit | input | 1 | Software-toggled phase bit, asynchronous |
| kill | input | 1 | Asynchronous force-low of both outputs |
| per_wr | input | 1 | Period register write strobe |
| per_wdata | input | CNT_W | Period value to write |
| count_rd | output | CNT_W | Current down-counter value |
| ph_pri | output | 1 | Primary phase output (high input level) |
| ph_aux | output | 1 | Auxiliary phase output (low input level) |

## Verification
The bench drives isolated rising and falling PWM edges with several periods, including zero. These show which output each level selects and that the gap is exactly P+1 cycles. A second edge inside the gap tells a counter that restarts apart from one that simply finishes its first count. Kill is asserted while an output is high, and later edges show that the outputs recover only through a new count. Software-bit edges separate the two-cycle synchroniser latency from the direct PWM path, while toggles of the unselected input and edges during disable show that they leave the outputs and count untouched.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  // Low time of both outputs between phases, in clock cycles, for period p.
  function automatic int unsigned gap_cycles(input int unsigned p);
    return p + 1;
  endfunction

  // One step of the dead-time down counter; saturates at zero.
  function automatic logic [31:0] count_step(input logic [31:0] c);
    return (c == 32'd0) ? 32'd0 : c - 32'd1;
  endfunction

  typedef enum logic [0:0] {
    SRC_PWM = 1'b0,
    SRC_SW  = 1'b1
  } src_e;

endpackage

// File: rtl/dbg_phase_src.sv
module dbg_phase_src #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel,
  input  logic pwm_in,
  input  logic sw_bit,
  output logic lvl,
  output logic edge_evt
);
  import dbg_pkg::*;

  logic [SYNC_N-1:0] sync_q;
  logic              sw_s;
  logic              sel_lvl;
  logic              prev_q;

  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sw_bit;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-2:0], sw_bit};
      end
    end
  endgenerate

  assign sw_s    = sync_q[SYNC_N-1];
  assign sel_lvl = (src_e'(src_sel) == SRC_SW) ? sw_s : pwm_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel_lvl;
  end

  assign edge_evt = sel_lvl ^ prev_q;
  assign lvl      = prev_q;

endmodule

// File: rtl/dbg_dead_timer.sv
module dbg_dead_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             kill,
  input  logic             edge_evt,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             done_evt
);
  import dbg_pkg::*;

  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [31:0]      step_w;

  assign step_w = count_step(32'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= ZERO;
      cnt_q    <= ZERO;
      run_q    <= 1'b0;
    end else begin
      if (per_wr) period_q <= per_wdata;
      if (!enable) begin
        run_q <= 1'b0;
        if (per_wr) cnt_q <= per_wdata;
      end else if (kill) begin
        run_q <= 1'b0;
      end else if (edge_evt) begin
        cnt_q <= period_q;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == ZERO) run_q <= 1'b0;
        else               cnt_q <= step_w[CNT_W-1:0];
      end
    end
  end

  assign done_evt = run_q && (cnt_q == ZERO) && enable && !kill && !edge_evt;
  assign period   = period_q;
  assign count    = cnt_q;
  assign running  = run_q;

endmodule

// File: rtl/dbg_phase_out.sv
module dbg_phase_out (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic kill,
  input  logic edge_evt,
  input  logic done_evt,
  input  logic lvl,
  output logic ph_pri,
  output logic ph_aux
);
  logic pri_q;
  logic aux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= 1'b0;
      aux_q <= 1'b0;
    end else if (!enable || kill || edge_evt) begin
      pri_q <= 1'b0;
      aux_q <= 1'b0;
    end else if (done_evt) begin
      pri_q <= lvl;
      aux_q <= ~lvl;
    end
  end

  // Kill gates the registered phases without waiting for a clock.
  assign ph_pri = pri_q & ~kill;
  assign ph_aux = aux_q & ~kill;

endmodule

// File: rtl/dead_band_gen.sv
module dead_band_gen #(
  parameter int CNT_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             src_sel,
  input  logic             pwm_in,
  input  logic             sw_bit,
  input  logic             kill,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CNT_W-1:0] count_rd,
  output logic             ph_pri,
  output logic             ph_aux
);

  logic             edge_evt;
  logic             done_evt;
  logic             lvl_w;
  logic             run_w;
  logic [CNT_W-1:0] period_w;

  dbg_phase_src #(.SYNC_N(SYNC_N)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .pwm_in   (pwm_in),
    .sw_bit   (sw_bit),
    .lvl      (lvl_w),
    .edge_evt (edge_evt)
  );

  dbg_dead_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .kill      (kill),
    .edge_evt  (edge_evt),
    .per_wr    (per_wr),
    .per_wdata (per_wdata),
    .period    (period_w),
    .count     (count_rd),
    .running   (run_w),
    .done_evt  (done_evt)
  );

  dbg_phase_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .kill     (kill),
    .edge_evt (edge_evt),
    .done_evt (done_evt),
    .lvl      (lvl_w),
    .ph_pri   (ph_pri),
    .ph_aux   (ph_aux)
  );

endmodule

// File: rtl/dbg_checker.sv
module dbg_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             kill,
  input logic             per_wr,
  input logic [CNT_W-1:0] per_wdata,
  input logic [CNT_W-1:0] count_rd,
  input logic             ph_pri,
  input logic             ph_aux,
  input logic             edge_evt,
  input logic             done_evt,
  input logic             run_w,
  input logic [CNT_W-1:0] period_w
);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_pri && ph_aux));

  a_r9_kill_low: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (!ph_pri && !ph_aux));

  a_r3_edge_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && edge_evt) |=> (!ph_pri && !ph_aux));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !kill && edge_evt) |=> (count_rd == $past(period_w)));

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !kill && !edge_evt && !per_wr && run_w && count_rd != '0)
      |=> (count_rd == $past(count_rd) - 1'b1));

  a_r10_rise_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ph_pri) || $rose(ph_aux)) |-> $past(done_evt));

  a_r7_disabled_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && per_wr) |=> (count_rd == $past(per_wdata)));

  a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !per_wr) |=> ($stable(count_rd) && !ph_pri && !ph_aux));

endmodule

bind dead_band_gen dbg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .kill      (kill),
  .per_wr    (per_wr),
  .per_wdata (per_wdata),
  .count_rd  (count_rd),
  .ph_pri    (ph_pri),
  .ph_aux    (ph_aux),
  .edge_evt  (edge_evt),
  .done_evt  (done_evt),
  .run_w     (run_w),
  .period_w  (period_w)
);

// File: tb/tb_dead_band_gen.sv
module tb_dead_band_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         src_sel = 1'b0;
  logic         pwm_in = 1'b0;
  logic         sw_bit = 1'b0;
  logic         kill = 1'b0;
  logic         per_wr = 1'b0;
  logic [W-1:0] per_wdata = '0;
  logic [W-1:0] count_rd;
  logic         ph_pri;
  logic         ph_aux;

  dead_band_gen #(.CNT_W(W), .SYNC_N(2)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
    .pwm_in(pwm_in), .sw_bit(sw_bit), .kill(kill), .per_wr(per_wr),
    .per_wdata(per_wdata), .count_rd(count_rd), .ph_pri(ph_pri), .ph_aux(ph_aux)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int       cy;
    logic     a;
    logic     b;
    bit       cc;
    logic [W-1:0] cnt;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   overlap_seen = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int cy, input logic a, input logic b, input bit cc,
                      input logic [W-1:0] cnt, input string tag);
    exp_t e;
    e.cy = cy; e.a = a; e.b = b; e.cc = cc; e.cnt = cnt; e.tag = tag;
    q.push_back(e);
  endtask

  // Expected trace of one dead-time gap: edge detected at clock d.
  task automatic gap_seq(input int d, input int p, input logic lvl, input string tag);
    for (int i = 0; i <= p; i++) push(d + i, 1'b0, 1'b0, 1'b1, W'(p - i), tag);
    push(d + p + 1, lvl, ~lvl, 1'b1, '0, tag);
  endtask

  // Monitor: compares outputs against queued expectations at the falling edge.
  always @(negedge clk) begin
    if (rst_n && ph_pri && ph_aux) overlap_seen = 1'b1;
    while (q.size() > 0 && q[0].cy <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.cy < cyc) chk({e.tag, " stale"}, 32'(cyc), 32'(e.cy));
      else begin
        chk({e.tag, " pri"}, 32'(ph_pri), 32'(e.a));
        chk({e.tag, " aux"}, 32'(ph_aux), 32'(e.b));
        if (e.cc) chk({e.tag, " count"}, 32'(count_rd), 32'(e.cnt));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drain();
    while (q.size() != 0) step();
    step();
  endtask

  task automatic wr_per(input logic [W-1:0] v);
    per_wr = 1'b1; per_wdata = v;
    step();
    per_wr = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      checks++;
      if (overlap_seen) begin
        fails++;
        $display("FAIL R2 actual=overlap expected=no overlap");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    // R1: reset state
    repeat (3) step();
    chk("R1 reset pri", 32'(ph_pri), 0);
    chk("R1 reset aux", 32'(ph_aux), 0);
    chk("R1 reset count", 32'(count_rd), 0);
    rst_n = 1'b1;
    step();
    chk("R1 after release count", 32'(count_rd), 0);

    // R7: disabled write presets count
    push(cyc + 1, 1'b0, 1'b0, 1'b1, 8'd3, "R7 disabled load");
    wr_per(8'd3);
    drain();
    enable = 1'b1;
    step();

    // R4/R5/R3: rising edge, P=3 -> primary
    pwm_in = 1'b1;
    gap_seq(cyc + 1, 3, 1'b1, "R4 R5 rise P3");
    drain();
    // R5: falling edge -> auxiliary
    pwm_in = 1'b0;
    gap_seq(cyc + 1, 3, 1'b0, "R3 R5 fall P3");
    drain();

    // R7: enabled write leaves count readback alone
    push(cyc + 1, 1'b0, 1'b1, 1'b1, 8'd0, "R7 enabled write");
    wr_per(8'd6);
    drain();
    pwm_in = 1'b1;
    gap_seq(cyc + 1, 6, 1'b1, "R7 new period P6");
    drain();

    // R6: retrigger inside the gap
    begin
      int c;
      c = cyc;
      pwm_in = 1'b0;
      push(c + 1, 1'b0, 1'b0, 1'b1, 8'd6, "R6 first gap");
      push(c + 2, 1'b0, 1'b0, 1'b1, 8'd5, "R6 first gap");
      push(c + 3, 1'b0, 1'b0, 1'b1, 8'd4, "R6 first gap");
      step(); step(); step();
      pwm_in = 1'b1;
      gap_seq(c + 4, 6, 1'b1, "R6 restart");
      drain();
    end

    // R9: kill drops outputs without a clock edge
    @(negedge clk); #1;
    kill = 1'b1;
    #1;
    chk("R9 kill immediate pri", 32'(ph_pri), 0);
    chk("R9 kill immediate aux", 32'(ph_aux), 0);
    repeat (3) step();
    kill = 1'b0;
    // R10: outputs stay low after release
    for (int i = 0; i < 5; i++) push(cyc + i, 1'b0, 1'b0, 1'b0, '0, "R10 post-kill low");
    drain();
    pwm_in = 1'b0;
    gap_seq(cyc + 1, 6, 1'b0, "R10 recover");
    drain();

    // R11: software bit source, two-cycle synchroniser
    src_sel = 1'b1;
    step(); step();
    wr_per(8'd2);
    step();
    sw_bit = 1'b1;
    gap_seq(cyc + 3, 2, 1'b1, "R11 sw edge");
    drain();
    // R11: unselected PWM toggles ignored
    pwm_in = 1'b1;
    for (int i = 1; i <= 4; i++) push(cyc + i, 1'b1, 1'b0, 1'b1, 8'd0, "R11 pwm ignored");
    drain();

    // R8: disable drops outputs and freezes count
    enable = 1'b0;
    push(cyc + 1, 1'b0, 1'b0, 1'b1, 8'd0, "R8 disable low");
    drain();
    push(cyc + 1, 1'b0, 1'b0, 1'b1, 8'd5, "R7 disabled load 5");
    wr_per(8'd5);
    drain();
    sw_bit = 1'b0;
    for (int i = 1; i <= 5; i++) push(cyc + i, 1'b0, 1'b0, 1'b1, 8'd5, "R8 edge while disabled");
    drain();
    push(cyc + 1, 1'b0, 1'b0, 1'b1, 8'd0, "R7 disabled load 0");
    wr_per(8'd0);
    drain();
    pwm_in = 1'b0;
    step();
    src_sel = 1'b0;
    step();
    enable = 1'b1;
    step();

    // R4 boundary: P=0 gives a one-cycle gap
    pwm_in = 1'b1;
    gap_seq(cyc + 1, 0, 1'b1, "R4 P0 boundary");
    drain();
    chk("R5 final pri", 32'(ph_pri), 1);

    finish_up();
  end

endmodule